// File: doc/BRIEF.md
# Boot-Stream Capture Controller

This controller sits on the host side of a serial flash that has been set up to stream boot code as soon as its own reset ends. The host sends no opcode and no address. Once it is told to start, the controller pulls chip select low and runs a divided serial clock. It lets a configured number of clock cycles go by, because the flash sends nothing useful during that delay. After that it assembles a configured number of bytes from the incoming stream and presents each byte for one cycle with a valid strobe. It then parks the serial clock low, raises chip select to end the stream, and pulses done.

Three inputs set up the transfer: the start-delay count (8 bits), the lane mode, and the byte count. They are sampled together on the accepted start request. In single-lane mode, one bit arrives per serial clock on lane 0. In four-lane mode, a nibble arrives per serial clock on all four lanes. The controller runs once per reset. After it finishes it stays halted until the next reset.

The state machine has six states. IDLE waits for start. LEAD counts the delay edges. STREAM captures data. TRAIL waits for the serial clock to return low. FINISH raises chip select and pulses done. HALT holds everything idle until reset. The transitions are:
- IDLE to LEAD on start with a nonzero delay.
- IDLE to STREAM on start with a zero delay.
- LEAD to STREAM on the last delay edge.
- STREAM to TRAIL on the rising edge that completes the final byte.
- TRAIL to FINISH on the next falling edge.
- FINISH to HALT unconditionally.

Top module: `boot_fetch_engine`

## Requirements
- R1: While reset is asserted and afterwards until start, `flash_cs_n` is 1, `flash_sclk` is 0, `byte_valid` is 0 and `done` is 0.
- R2: On an accepted start, `flash_cs_n` falls. The first rising edge of `flash_sclk` follows CLK_DIV/2 system cycles later. The serial clock then has a period of CLK_DIV system cycles (CLK_DIV even, at least 2). It toggles only while chip select is low.
- R3: Data in the `flash_io` samples is ignored on exactly `start_delay` rising edges of the serial clock. With a delay of 0, the first rising edge already carries data.
- R4: With `quad_sel` = 0, lane `flash_io[0]` is sampled on each rising edge. Each byte takes 8 edges and is assembled MSB first.
- R5: With `quad_sel` = 1, `flash_io[3:0]` is sampled on each rising edge. Each byte takes 2 edges: the first edge supplies bits 7:4 and the second supplies bits 3:0.
- R6: Each completed byte appears on `byte_data` together with a single-cycle `byte_valid` pulse. Exactly the requested number of bytes is delivered.
- R7: A `byte_count` of 0 is treated as 1.
- R8: After the edge that completes the last byte, the serial clock returns low and chip select then rises. No further rising edges occur. The total number of rising edges under chip select equals the delay plus the byte count times the edges per byte.
- R9: `done` pulses for exactly one cycle, in the cycle where `flash_cs_n` has just gone high.
- R10: After completion, further start requests are ignored until reset. Chip select stays high and no bytes or done pulses are produced.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin the one-time fetch |
| start_delay | input | 8 | Serial clock cycles to skip before data |
| quad_sel | input | 1 | 1 = four data lanes, 0 = lane 0 only |
| byte_count | input | CNT_W | Bytes to capture (0 treated as 1) |
| flash_io | input | 4 | Data lanes from the flash |
| flash_cs_n | output | 1 | Active-low chip select |
| flash_sclk | output | 1 | Serial clock to the flash |
| byte_data | output | 8 | Captured byte |
| byte_valid | output | 1 | One-cycle strobe for byte_data |
| done | output | 1 | One-cycle pulse at the end of the fetch |

## Verification
The bench models the flash as a stream whose lane value depends on the index of each rising edge. Any miscount of the delay, whether one edge short or one too many, therefore shifts every captured byte and shows up as wrong data. The bench covers these corner cases:
- Zero delay and the largest delay, 255. These catch a controller that treats zero as 256 or wraps the delay counter.
- Single-byte transfers in both lane modes, a byte count of 0, and a restart after completion. These catch an off-by-one stop, a missing clamp, or a second run.
- Lane mode against lane use and nibble order. Because the bench drives distinct values on the unused lanes, a serial capture from the wrong lane, or swapped nibbles in four-lane mode, gives wrong bytes.
- Chip-select timing. Chip select rising while the clock is high, or an extra edge after the last byte, shows up in the edge count and the clock-level check.

// File: rtl/boot_fetch_pkg.sv
package boot_fetch_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LEAD,
        ST_STREAM,
        ST_TRAIL,
        ST_FINISH,
        ST_HALT
    } fetch_state_t;

    localparam int SERIAL_BEATS = 8;
    localparam int QUAD_BEATS   = 2;

endpackage

// File: rtl/bf_sclk_div.sv
module bf_sclk_div #(
    parameter int CLK_DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic sclk,
    output logic rise_tick,
    output logic fall_tick
);
    localparam int HALF = CLK_DIV / 2;
    localparam int CW   = (HALF > 1) ? $clog2(HALF) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF - 1);

    generate
        if (CLK_DIV < 2 || (CLK_DIV % 2) != 0) begin : g_bad_div
            $error("CLK_DIV must be even and at least 2");
        end
    endgenerate

    logic [CW-1:0] phase_cnt;
    logic          wrap;

    assign wrap      = run && (phase_cnt == LAST);
    assign rise_tick = wrap && !sclk;
    assign fall_tick = wrap && sclk;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_cnt <= '0;
            sclk      <= 1'b0;
        end else if (!run) begin
            phase_cnt <= '0;
            sclk      <= 1'b0;
        end else if (wrap) begin
            phase_cnt <= '0;
            sclk      <= ~sclk;
        end else begin
            phase_cnt <= phase_cnt + 1'b1;
        end
    end

endmodule

// File: rtl/bf_byte_assembler.sv
module bf_byte_assembler
    import boot_fetch_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clear,
    input  logic       shift_en,
    input  logic       quad,
    input  logic [3:0] lanes,
    output logic       last_beat,
    output logic [7:0] byte_out,
    output logic       byte_strobe
);
    logic [7:0] shreg;
    logic [2:0] beat;
    logic [2:0] beat_limit;
    logic [7:0] shreg_next;

    always_comb begin
        if (quad) begin
            beat_limit = 3'(QUAD_BEATS - 1);
            shreg_next = {shreg[3:0], lanes};
        end else begin
            beat_limit = 3'(SERIAL_BEATS - 1);
            shreg_next = {shreg[6:0], lanes[0]};
        end
    end

    assign last_beat = shift_en && (beat == beat_limit);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg       <= '0;
            beat        <= '0;
            byte_out    <= '0;
            byte_strobe <= 1'b0;
        end else begin
            byte_strobe <= 1'b0;
            if (clear) begin
                shreg <= '0;
                beat  <= '0;
            end else if (shift_en) begin
                shreg <= shreg_next;
                if (last_beat) begin
                    beat        <= '0;
                    byte_out    <= shreg_next;
                    byte_strobe <= 1'b1;
                end else begin
                    beat <= beat + 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/boot_fetch_engine.sv
module boot_fetch_engine
    import boot_fetch_pkg::*;
#(
    parameter int CLK_DIV = 4,
    parameter int CNT_W   = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [7:0]       start_delay,
    input  logic             quad_sel,
    input  logic [CNT_W-1:0] byte_count,
    input  logic [3:0]       flash_io,
    output logic             flash_cs_n,
    output logic             flash_sclk,
    output logic [7:0]       byte_data,
    output logic             byte_valid,
    output logic             done
);
    fetch_state_t     state;
    logic [7:0]       dly_left;
    logic [CNT_W-1:0] bytes_left;
    logic             quad_q;
    logic             clk_run;
    logic             rise_tick;
    logic             fall_tick;
    logic             shift_en;
    logic             byte_end;
    logic             accept;

    assign accept   = (state == ST_IDLE) && start;
    assign shift_en = (state == ST_STREAM) && rise_tick;

    bf_sclk_div #(.CLK_DIV(CLK_DIV)) u_div (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (clk_run),
        .sclk      (flash_sclk),
        .rise_tick (rise_tick),
        .fall_tick (fall_tick)
    );

    bf_byte_assembler u_asm (
        .clk         (clk),
        .rst_n       (rst_n),
        .clear       (accept),
        .shift_en    (shift_en),
        .quad        (quad_q),
        .lanes       (flash_io),
        .last_beat   (byte_end),
        .byte_out    (byte_data),
        .byte_strobe (byte_valid)
    );

    // State register and transfer counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            dly_left   <= '0;
            bytes_left <= '0;
            quad_q     <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        quad_q     <= quad_sel;
                        dly_left   <= start_delay;
                        bytes_left <= (byte_count == '0) ? CNT_W'(1) : byte_count;
                        state      <= (start_delay == 8'd0) ? ST_STREAM : ST_LEAD;
                    end
                end
                ST_LEAD: begin
                    if (rise_tick) begin
                        dly_left <= dly_left - 8'd1;
                        if (dly_left == 8'd1) state <= ST_STREAM;
                    end
                end
                ST_STREAM: begin
                    if (byte_end) begin
                        bytes_left <= bytes_left - 1'b1;
                        if (bytes_left == CNT_W'(1)) state <= ST_TRAIL;
                    end
                end
                ST_TRAIL: begin
                    if (fall_tick) state <= ST_FINISH;
                end
                ST_FINISH: state <= ST_HALT;
                ST_HALT:   state <= ST_HALT;
                default:   state <= ST_HALT;
            endcase
        end
    end

    // Outputs decoded from state
    always_comb begin
        clk_run    = 1'b0;
        flash_cs_n = 1'b1;
        done       = 1'b0;
        unique case (state)
            ST_LEAD, ST_STREAM, ST_TRAIL: begin
                clk_run    = 1'b1;
                flash_cs_n = 1'b0;
            end
            ST_FINISH: done = 1'b1;
            ST_IDLE, ST_HALT: ;
            default: ;
        endcase
    end

endmodule

// File: rtl/bf_checker.sv
module bf_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       flash_cs_n,
    input logic       flash_sclk,
    input logic       byte_valid,
    input logic       done
);
    logic finished;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    finished <= 1'b0;
        else if (done) finished <= 1'b1;
    end

    assert_idle_clock_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
        flash_cs_n |-> !flash_sclk);

    assert_edge_in_frame_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flash_sclk) |-> !flash_cs_n);

    assert_strobe_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        byte_valid |=> !byte_valid);

    assert_strobe_in_frame_R6: assert property (@(posedge clk) disable iff (!rst_n)
        byte_valid |-> !flash_cs_n);

    assert_release_clock_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flash_cs_n) |-> !flash_sclk);

    assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_at_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (flash_cs_n && $rose(flash_cs_n)));

    assert_single_run_R10: assert property (@(posedge clk) disable iff (!rst_n)
        finished |-> (flash_cs_n && !done && !byte_valid));

endmodule

bind boot_fetch_engine bf_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .flash_cs_n (flash_cs_n),
    .flash_sclk (flash_sclk),
    .byte_valid (byte_valid),
    .done       (done)
);

// File: tb/tb_boot_fetch_engine.sv
`timescale 1ns/1ps
module tb_boot_fetch_engine;
    localparam int CLK_PERIOD = 10;
    localparam int DIV        = 4;
    localparam int CW         = 16;
    localparam int MAXB       = 16;

    typedef struct packed {
        logic [7:0] dly;
        logic       quad;
        logic [7:0] cnt;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{8'd0,   1'b0, 8'd1},
        '{8'd0,   1'b1, 8'd1},
        '{8'd3,   1'b0, 8'd2},
        '{8'd5,   1'b1, 8'd3},
        '{8'd255, 1'b1, 8'd2},
        '{8'd1,   1'b0, 8'd4}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [7:0]    start_delay = '0;
    logic          quad_sel = 1'b0;
    logic [CW-1:0] byte_count = '0;
    logic [3:0]    flash_io;
    logic          flash_cs_n, flash_sclk, byte_valid, done;
    logic [7:0]    byte_data;

    int  n_checks = 0;
    int  n_fail   = 0;
    int  edge_idx = 0;
    int  nbytes   = 0;
    int  ndone    = 0;
    int  cs_low_cycles = 0;
    bit  sclk_high_at_release = 0;
    logic prev_cs = 1'b1;
    logic [7:0] got [MAXB];
    time t_csfall = 0;
    time t_rise0  = 0;
    time t_rise1  = 0;

    boot_fetch_engine #(.CLK_DIV(DIV), .CNT_W(CW)) dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .start_delay (start_delay),
        .quad_sel    (quad_sel),
        .byte_count  (byte_count),
        .flash_io    (flash_io),
        .flash_cs_n  (flash_cs_n),
        .flash_sclk  (flash_sclk),
        .byte_data   (byte_data),
        .byte_valid  (byte_valid),
        .done        (done)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [3:0] pat(int k);
        return 4'(k * 13 + (k >> 3) * 7 + 1);
    endfunction

    assign flash_io = pat(edge_idx);

    always @(negedge flash_cs_n) t_csfall = $time;

    always @(posedge flash_sclk) begin
        if (!flash_cs_n) begin
            if (edge_idx == 0) t_rise0 = $time;
            if (edge_idx == 1) t_rise1 = $time;
            edge_idx = edge_idx + 1;
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            if (byte_valid) begin
                if (nbytes < MAXB) got[nbytes] = byte_data;
                nbytes = nbytes + 1;
            end
            if (done) ndone = ndone + 1;
            if (!flash_cs_n) cs_low_cycles = cs_low_cycles + 1;
            if (!prev_cs && flash_cs_n && flash_sclk) sclk_high_at_release = 1;
        end
        prev_cs = flash_cs_n;
    end

    task automatic check(bit ok, string req, int act, int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        start = 1'b0;
        repeat (3) @(negedge clk);
        edge_idx = 0; nbytes = 0; ndone = 0; cs_low_cycles = 0;
        sclk_high_at_release = 0;
        t_csfall = 0; t_rise0 = 0; t_rise1 = 0;
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic pulse_start();
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic run_case(logic [7:0] d, logic q, logic [CW-1:0] n, string tag);
        int beats, nexp, guard;
        logic [7:0] exp_b;
        do_reset();
        start_delay = d; quad_sel = q; byte_count = n;
        pulse_start();
        // change config mid-run: must not matter since it is sampled at start
        start_delay = 8'd77; quad_sel = ~q; byte_count = CW'(9);
        guard = 0;
        while (ndone == 0 && guard < 20000) begin
            @(negedge clk);
            guard++;
        end
        check(guard < 20000, {tag, " R9 timeout"}, guard, 0);
        repeat (10) @(negedge clk);
        beats = q ? 2 : 8;
        nexp  = (n == 0) ? 1 : int'(n);
        check(nbytes == nexp, {tag, " R6 byte count"}, nbytes, nexp);
        if (n == 0) check(nbytes == 1, {tag, " R7 zero clamp"}, nbytes, 1);
        for (int j = 0; j < nexp && j < MAXB && j < nbytes; j++) begin
            if (q) begin
                exp_b = {pat(int'(d) + 2*j), pat(int'(d) + 2*j + 1)};
            end else begin
                for (int i = 0; i < 8; i++) exp_b[7-i] = pat(int'(d) + 8*j + i)[0];
            end
            check(got[j] == exp_b, {tag, q ? " R5 quad byte R3" : " R4 serial byte R3"},
                  int'(got[j]), int'(exp_b));
        end
        check(edge_idx == int'(d) + nexp*beats, {tag, " R8 edge total"},
              edge_idx, int'(d) + nexp*beats);
        check(ndone == 1, {tag, " R9 done pulses"}, ndone, 1);
        check(flash_cs_n == 1'b1 && flash_sclk == 1'b0, {tag, " R8 released"},
              int'({flash_cs_n, flash_sclk}), 2);
        check(!sclk_high_at_release, {tag, " R8 clock low at release"},
              int'(sclk_high_at_release), 0);
        check(t_rise0 - t_csfall == (DIV/2)*CLK_PERIOD, {tag, " R2 lead time"},
              int'(t_rise0 - t_csfall), (DIV/2)*CLK_PERIOD);
        if (edge_idx >= 2)
            check(t_rise1 - t_rise0 == DIV*CLK_PERIOD, {tag, " R2 clock period"},
                  int'(t_rise1 - t_rise0), DIV*CLK_PERIOD);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual 1 expected 0");
        finish_run();
    end

    initial begin : main
        int cyc_before, bytes_before, edges_before;
        // R1: reset state
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check(flash_cs_n == 1 && flash_sclk == 0 && byte_valid == 0 && done == 0,
              "R1 in reset", int'({flash_cs_n, flash_sclk, byte_valid, done}), 8);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        check(flash_cs_n == 1 && flash_sclk == 0 && byte_valid == 0 && done == 0,
              "R1 idle before start", int'({flash_cs_n, flash_sclk, byte_valid, done}), 8);

        for (int v = 0; v < 6; v++)
            run_case(VECS[v].dly, VECS[v].quad, CW'(VECS[v].cnt), $sformatf("vec%0d", v));

        // R7: zero byte count yields one byte
        run_case(8'd2, 1'b0, CW'(0), "zero_count");
        run_case(8'd0, 1'b1, CW'(0), "zero_count_quad");

        // R10: restart after completion is ignored
        run_case(8'd1, 1'b1, CW'(2), "restart");
        cyc_before   = cs_low_cycles;
        bytes_before = nbytes;
        edges_before = edge_idx;
        start_delay = 8'd0; quad_sel = 1'b1; byte_count = CW'(3);
        pulse_start();
        repeat (200) @(negedge clk);
        check(cs_low_cycles == cyc_before, "R10 cs stays high", cs_low_cycles, cyc_before);
        check(nbytes == bytes_before, "R10 no new bytes", nbytes, bytes_before);
        check(edge_idx == edges_before, "R10 no new edges", edge_idx, edges_before);
        check(ndone == 1, "R10 no second done", ndone, 1);

        finish_run();
    end

endmodule